// File: doc/BRIEF.md
# Two-Port Doorbell Mailbox Register Block

This block is a shared register file through which a host processor and a DSP signal each other. Each direction has a narrow doorbell command register. While any of its bits is set, a level interrupt is held toward the receiving processor. The receiver acknowledges by writing ones to a companion clear register. In the larger layout, each direction also has a bank of plain 32-bit scratch words that carry short message payloads.

Each processor has its own memory-mapped register port. The two ports see one common word-indexed address map, and the names follow the DSP's view: the inbound doorbell interrupts the DSP and the outbound doorbell interrupts the host. Each port is a simple select/write-enable register port, not a stream. A read is always accepted and answers one cycle later with a valid strobe. No back-pressure exists in either direction, so the block needs no ready signal. The parameter `WITH_MSG` selects between two layouts: one with scratch banks and one compact layout with doorbells only.

Top module: `ipc_mbox_regs`

## Requirements
- R1: A doorbell command register holds only `CMD_W` (5) bits. On read, bits 31..5 are zero, and written values above bit 4 are discarded.
- R2: `irq_dsp` is high exactly while the inbound command is nonzero, and `irq_host` is high exactly while the outbound command is nonzero. Both follow the register on the clock edge that updates it.
- R3: Writing a mask to a clear register clears the command bits that are one in the mask. Zero bits in the mask leave their command bits unchanged.
- R4: A write to a command register replaces its content with the written low 5 bits. Earlier bits survive only if they are written back.
- R5: A command write and a clear write to the same direction in the same cycle take the command write's value. A bit written as one stays set even when the clear targets it.
- R6: With `WITH_MSG`=1, each direction has `MSG_WORDS` (5) read/write 32-bit scratch words that are reachable from both ports and have no effect on the doorbells or interrupts.
- R7: When both ports write the same command register or the same scratch word in one cycle, the host port's data is stored.
- R8: A read (`sel`=1, `we`=0) returns data one cycle later with `rvalid`=1. The data is the register content before any write in the same cycle. When no read is made, the next cycle shows `rvalid`=0 and `rdata`=0.
- R9: Clear registers read as zero. Addresses outside the map read as zero, and writes to them change nothing.
- R10: In the `WITH_MSG`=1 layout the word addresses are 0 inbound command, 1 inbound clear, 2..6 inbound scratch, 7 outbound command, 8 outbound clear, and 9..13 outbound scratch.
- R11: In the `WITH_MSG`=0 layout the word addresses are 0 inbound command, 1 outbound command, 2 inbound clear, and 3 outbound clear. Every other address is unmapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_sel | input | 1 | Host port access strobe |
| host_we | input | 1 | Host port write (1) or read (0) |
| host_addr | input | ADDR_W | Host port word address |
| host_wdata | input | DATA_W | Host port write data |
| host_rdata | output | DATA_W | Host port read data, one cycle after the read |
| host_rvalid | output | 1 | Host port read data valid |
| dsp_sel | input | 1 | DSP port access strobe |
| dsp_we | input | 1 | DSP port write (1) or read (0) |
| dsp_addr | input | ADDR_W | DSP port word address |
| dsp_wdata | input | DATA_W | DSP port write data |
| dsp_rdata | output | DATA_W | DSP port read data, one cycle after the read |
| dsp_rvalid | output | 1 | DSP port read data valid |
| irq_dsp | output | 1 | Interrupt to the DSP (inbound doorbell nonzero) |
| irq_host | output | 1 | Interrupt to the host (outbound doorbell nonzero) |

## Verification
Every result is due exactly one cycle after the access that causes it. Read data and `rvalid` appear in the cycle after the read strobe. Command and scratch updates, and the interrupt levels, appear in the cycle after the write. The bench applies each cycle's port activity to its own model before the rising edge, with the model reading the pre-write state. It then compares every output of both layout instances on the following falling edge. As a result, same-cycle read/write, set/clear and host/DSP collisions are all checked at the one cycle where they become visible.

// File: rtl/ipc_mbox_pkg.sv
package ipc_mbox_pkg;

  typedef enum logic [1:0] {
    RK_NONE = 2'd0,
    RK_CMD  = 2'd1,
    RK_CLR  = 2'd2,
    RK_MSG  = 2'd3
  } reg_kind_e;

  // decoded register target of one port access
  typedef struct packed {
    reg_kind_e  kind;
    logic       dir;   // 0: inbound (to DSP), 1: outbound (to host)
    logic [2:0] idx;   // scratch word index
  } reg_sel_t;

  localparam int PORT_HOST = 0;
  localparam int PORT_DSP  = 1;

  function automatic int cmd_word(input int dir, input bit with_msg, input int msg_words);
    return with_msg ? dir * (msg_words + 2) : dir;
  endfunction

  function automatic int clr_word(input int dir, input bit with_msg, input int msg_words);
    return with_msg ? dir * (msg_words + 2) + 1 : 2 + dir;
  endfunction

  function automatic int msg_word(input int dir, input int i, input int msg_words);
    return dir * (msg_words + 2) + 2 + i;
  endfunction

endpackage

// File: rtl/ipc_addr_decode.sv
module ipc_addr_decode
  import ipc_mbox_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter bit WITH_MSG  = 1'b1,
  parameter int MSG_WORDS = 5
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_t          sel
);

  always_comb begin
    sel.kind = RK_NONE;
    sel.dir  = 1'b0;
    sel.idx  = '0;
    for (int d = 0; d < 2; d++) begin
      if (addr == ADDR_W'(cmd_word(d, WITH_MSG, MSG_WORDS))) begin
        sel.kind = RK_CMD;
        sel.dir  = 1'(d);
      end
      if (addr == ADDR_W'(clr_word(d, WITH_MSG, MSG_WORDS))) begin
        sel.kind = RK_CLR;
        sel.dir  = 1'(d);
      end
      if (WITH_MSG) begin
        for (int i = 0; i < MSG_WORDS; i++) begin
          if (addr == ADDR_W'(msg_word(d, i, MSG_WORDS))) begin
            sel.kind = RK_MSG;
            sel.dir  = 1'(d);
            sel.idx  = 3'(i);
          end
        end
      end
    end
  end

endmodule

// File: rtl/ipc_doorbell.sv
module ipc_doorbell #(
  parameter int CMD_W = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [1:0]            wr,    // [0] host, [1] dsp command write
  input  logic [1:0][CMD_W-1:0] wval,
  input  logic [1:0]            clr,   // [0] host, [1] dsp clear write
  input  logic [1:0][CMD_W-1:0] cval,
  output logic [CMD_W-1:0]      cmd_q,
  output logic                  irq_q
);

  logic [CMD_W-1:0] clr_mask;
  logic [CMD_W-1:0] cmd_nxt;

  always_comb begin
    clr_mask = (clr[0] ? cval[0] : '0) | (clr[1] ? cval[1] : '0);
    // a command write overrides any clear: written ones survive
    if (wr[0])      cmd_nxt = wval[0];
    else if (wr[1]) cmd_nxt = wval[1];
    else            cmd_nxt = cmd_q & ~clr_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
      irq_q <= 1'b0;
    end else begin
      cmd_q <= cmd_nxt;
      irq_q <= |cmd_nxt;
    end
  end

endmodule

// File: rtl/ipc_scratch_bank.sv
module ipc_scratch_bank #(
  parameter int MSG_WORDS = 5,
  parameter int DATA_W    = 32
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [MSG_WORDS-1:0]                we_host,
  input  logic [MSG_WORDS-1:0]                we_dsp,
  input  logic [DATA_W-1:0]                   wd_host,
  input  logic [DATA_W-1:0]                   wd_dsp,
  output logic [MSG_WORDS-1:0][DATA_W-1:0]    words
);

  for (genvar i = 0; i < MSG_WORDS; i++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          words[i] <= '0;
      else if (we_host[i]) words[i] <= wd_host;
      else if (we_dsp[i])  words[i] <= wd_dsp;
    end
  end

endmodule

// File: rtl/ipc_read_port.sv
module ipc_read_port
  import ipc_mbox_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 32,
  parameter int CMD_W     = 5,
  parameter bit WITH_MSG  = 1'b1,
  parameter int MSG_WORDS = 5
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   sel,
  input  logic                                   we,
  input  logic [ADDR_W-1:0]                      addr,
  input  logic [1:0][CMD_W-1:0]                  cmd,
  input  logic [1:0][MSG_WORDS-1:0][DATA_W-1:0]  msg,
  output reg_sel_t                               dec,
  output logic [DATA_W-1:0]                      rdata,
  output logic                                   rvalid
);

  logic [DATA_W-1:0] rd_val;
  logic              rd_req;

  ipc_addr_decode #(
    .ADDR_W   (ADDR_W),
    .WITH_MSG (WITH_MSG),
    .MSG_WORDS(MSG_WORDS)
  ) u_dec (
    .addr(addr),
    .sel (dec)
  );

  always_comb begin
    case (dec.kind)
      RK_CMD:  rd_val = DATA_W'(cmd[dec.dir]);
      RK_MSG:  rd_val = msg[dec.dir][dec.idx];
      default: rd_val = '0;
    endcase
  end

  assign rd_req = sel & ~we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd_req;
      rdata  <= rd_req ? rd_val : '0;
    end
  end

endmodule

// File: rtl/ipc_mbox_regs.sv
module ipc_mbox_regs
  import ipc_mbox_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 32,
  parameter int CMD_W     = 5,
  parameter int MSG_WORDS = 5,
  parameter bit WITH_MSG  = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_sel,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_rvalid,
  input  logic              dsp_sel,
  input  logic              dsp_we,
  input  logic [ADDR_W-1:0] dsp_addr,
  input  logic [DATA_W-1:0] dsp_wdata,
  output logic [DATA_W-1:0] dsp_rdata,
  output logic              dsp_rvalid,
  output logic              irq_dsp,
  output logic              irq_host
);

  localparam int NPORT = 2;
  localparam int NDIR  = 2;

  logic [NPORT-1:0]              p_sel, p_we;
  logic [NPORT-1:0][ADDR_W-1:0]  p_addr;
  logic [NPORT-1:0][DATA_W-1:0]  p_wdata;
  reg_sel_t                      p_dec [NPORT];

  logic [NDIR-1:0][CMD_W-1:0]                  cmd_q;
  logic [NDIR-1:0]                             irq_q;
  logic [NDIR-1:0][MSG_WORDS-1:0][DATA_W-1:0]  msg_w;

  logic [CMD_W-1:0] in_cmd_w, out_cmd_w;

  assign p_sel   = {dsp_sel, host_sel};
  assign p_we    = {dsp_we, host_we};
  assign p_addr  = {dsp_addr, host_addr};
  assign p_wdata = {dsp_wdata, host_wdata};

  ipc_read_port #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CMD_W(CMD_W),
    .WITH_MSG(WITH_MSG), .MSG_WORDS(MSG_WORDS)
  ) u_rp_host (
    .clk(clk), .rst_n(rst_n),
    .sel(host_sel), .we(host_we), .addr(host_addr),
    .cmd(cmd_q), .msg(msg_w),
    .dec(p_dec[PORT_HOST]), .rdata(host_rdata), .rvalid(host_rvalid)
  );

  ipc_read_port #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CMD_W(CMD_W),
    .WITH_MSG(WITH_MSG), .MSG_WORDS(MSG_WORDS)
  ) u_rp_dsp (
    .clk(clk), .rst_n(rst_n),
    .sel(dsp_sel), .we(dsp_we), .addr(dsp_addr),
    .cmd(cmd_q), .msg(msg_w),
    .dec(p_dec[PORT_DSP]), .rdata(dsp_rdata), .rvalid(dsp_rvalid)
  );

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    logic [NPORT-1:0]            wr, clr;
    logic [NPORT-1:0][CMD_W-1:0] wv;

    always_comb begin
      for (int p = 0; p < NPORT; p++) begin
        wr[p]  = p_sel[p] & p_we[p] & (p_dec[p].kind == RK_CMD) & (p_dec[p].dir == 1'(d));
        clr[p] = p_sel[p] & p_we[p] & (p_dec[p].kind == RK_CLR) & (p_dec[p].dir == 1'(d));
        wv[p]  = p_wdata[p][CMD_W-1:0];
      end
    end

    ipc_doorbell #(.CMD_W(CMD_W)) u_db (
      .clk(clk), .rst_n(rst_n),
      .wr(wr), .wval(wv), .clr(clr), .cval(wv),
      .cmd_q(cmd_q[d]), .irq_q(irq_q[d])
    );

    if (WITH_MSG) begin : g_msg
      logic [MSG_WORDS-1:0] we_h, we_d;

      always_comb begin
        for (int i = 0; i < MSG_WORDS; i++) begin
          we_h[i] = host_sel & host_we & (p_dec[PORT_HOST].kind == RK_MSG) &
                    (p_dec[PORT_HOST].dir == 1'(d)) & (p_dec[PORT_HOST].idx == 3'(i));
          we_d[i] = dsp_sel & dsp_we & (p_dec[PORT_DSP].kind == RK_MSG) &
                    (p_dec[PORT_DSP].dir == 1'(d)) & (p_dec[PORT_DSP].idx == 3'(i));
        end
      end

      ipc_scratch_bank #(.MSG_WORDS(MSG_WORDS), .DATA_W(DATA_W)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .we_host(we_h), .we_dsp(we_d),
        .wd_host(host_wdata), .wd_dsp(dsp_wdata),
        .words(msg_w[d])
      );
    end else begin : g_nomsg
      assign msg_w[d] = '0;
    end
  end

  assign in_cmd_w  = cmd_q[0];
  assign out_cmd_w = cmd_q[1];
  assign irq_dsp   = irq_q[0];
  assign irq_host  = irq_q[1];

endmodule

// File: rtl/ipc_mbox_chk.sv
module ipc_mbox_chk
  import ipc_mbox_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 32,
  parameter int CMD_W     = 5,
  parameter int MSG_WORDS = 5,
  parameter bit WITH_MSG  = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_sel,
  input logic              host_we,
  input logic [ADDR_W-1:0] host_addr,
  input logic [DATA_W-1:0] host_wdata,
  input logic [DATA_W-1:0] host_rdata,
  input logic              host_rvalid,
  input logic              dsp_sel,
  input logic              dsp_we,
  input logic [ADDR_W-1:0] dsp_addr,
  input logic [CMD_W-1:0]  in_cmd,
  input logic [CMD_W-1:0]  out_cmd,
  input logic              irq_dsp,
  input logic              irq_host
);

  localparam logic [ADDR_W-1:0] IN_CMD_A  = ADDR_W'(cmd_word(0, WITH_MSG, MSG_WORDS));
  localparam logic [ADDR_W-1:0] OUT_CMD_A = ADDR_W'(cmd_word(1, WITH_MSG, MSG_WORDS));
  localparam logic [ADDR_W-1:0] IN_CLR_A  = ADDR_W'(clr_word(0, WITH_MSG, MSG_WORDS));

  logic h_rd, h_wr, d_wr;
  assign h_rd = host_sel & ~host_we;
  assign h_wr = host_sel & host_we;
  assign d_wr = dsp_sel & dsp_we;

  p_cmd_width_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (h_rd && host_addr == IN_CMD_A) |=>
      (host_rdata[DATA_W-1:CMD_W] == '0 && host_rdata[CMD_W-1:0] == $past(in_cmd)));

  p_irq_dsp_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_dsp == (in_cmd != '0));

  p_irq_host_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_host == (out_cmd != '0));

  p_clear_ones_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (h_wr && host_addr == IN_CLR_A && !(d_wr && dsp_addr == IN_CMD_A)) |=>
      ((in_cmd & $past(host_wdata[CMD_W-1:0])) == '0));

  p_host_cmd_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (h_wr && host_addr == OUT_CMD_A) |=> (out_cmd == $past(host_wdata[CMD_W-1:0])));

  p_read_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    h_rd |=> host_rvalid);

  p_no_read_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !h_rd |=> (!host_rvalid && host_rdata == '0));

  p_clr_reads_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (h_rd && host_addr == IN_CLR_A) |=> (host_rdata == '0));

endmodule

bind ipc_mbox_regs ipc_mbox_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CMD_W(CMD_W),
  .MSG_WORDS(MSG_WORDS), .WITH_MSG(WITH_MSG)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .host_sel(host_sel), .host_we(host_we), .host_addr(host_addr),
  .host_wdata(host_wdata), .host_rdata(host_rdata), .host_rvalid(host_rvalid),
  .dsp_sel(dsp_sel), .dsp_we(dsp_we), .dsp_addr(dsp_addr),
  .in_cmd(in_cmd_w), .out_cmd(out_cmd_w),
  .irq_dsp(irq_dsp), .irq_host(irq_host)
);

// File: tb/ipc_mbox_regs_bench.sv
module ipc_mbox_regs_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        h_sel = 0, h_we = 0, d_sel = 0, d_we = 0;
  logic [5:0]  h_addr = 0, d_addr = 0;
  logic [31:0] h_wd = 0, d_wd = 0;

  logic [31:0] a_hr, a_dr, b_hr, b_dr;
  logic        a_hv, a_dv, b_hv, b_dv, a_irqd, a_irqh, b_irqd, b_irqh;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  ipc_mbox_regs u_ipc_mbox_regs (
    .clk(clk), .rst_n(rst_n),
    .host_sel(h_sel), .host_we(h_we), .host_addr(h_addr), .host_wdata(h_wd),
    .host_rdata(a_hr), .host_rvalid(a_hv),
    .dsp_sel(d_sel), .dsp_we(d_we), .dsp_addr(d_addr), .dsp_wdata(d_wd),
    .dsp_rdata(a_dr), .dsp_rvalid(a_dv),
    .irq_dsp(a_irqd), .irq_host(a_irqh)
  );

  ipc_mbox_regs #(.WITH_MSG(1'b0)) u_ipc_mbox_regs_b (
    .clk(clk), .rst_n(rst_n),
    .host_sel(h_sel), .host_we(h_we), .host_addr(h_addr), .host_wdata(h_wd),
    .host_rdata(b_hr), .host_rvalid(b_hv),
    .dsp_sel(d_sel), .dsp_we(d_we), .dsp_addr(d_addr), .dsp_wdata(d_wd),
    .dsp_rdata(b_dr), .dsp_rvalid(b_dv),
    .irq_dsp(b_irqd), .irq_host(b_irqh)
  );

  // reference model: [variant 0 = with scratch, 1 = compact][direction]
  int unsigned cmdm [2][2];
  int unsigned msgm [2][2][5];
  int unsigned e_rd [2][2];
  bit          e_rv [2][2];
  bit          e_irq[2][2];
  string       e_tag[2][2];

  // kind: 0 unmapped, 1 command, 2 clear, 3 scratch
  task automatic lookup(input int v, input int a, output int kind, output int dir, output int idx);
    kind = 0; dir = 0; idx = 0;
    if (v == 0) begin
      if (a == 0)                 kind = 1;
      else if (a == 1)            kind = 2;
      else if (a >= 2 && a <= 6)  begin kind = 3; idx = a - 2; end
      else if (a == 7)            begin kind = 1; dir = 1; end
      else if (a == 8)            begin kind = 2; dir = 1; end
      else if (a >= 9 && a <= 13) begin kind = 3; dir = 1; idx = a - 9; end
    end else begin
      case (a)
        0: kind = 1;
        1: begin kind = 1; dir = 1; end
        2: kind = 2;
        3: begin kind = 2; dir = 1; end
        default: kind = 0;
      endcase
    end
  endtask

  task automatic model_step();
    bit s[2], w[2];
    int ad[2];
    int unsigned wd[2];
    int k, dr, ix;
    s[0] = h_sel; w[0] = h_we; ad[0] = int'(h_addr); wd[0] = h_wd;
    s[1] = d_sel; w[1] = d_we; ad[1] = int'(d_addr); wd[1] = d_wd;
    for (int v = 0; v < 2; v++) begin
      for (int p = 0; p < 2; p++) begin
        lookup(v, ad[p], k, dr, ix);
        e_rv[v][p] = s[p] && !w[p];
        e_rd[v][p] = 0;
        e_tag[v][p] = "R8";
        if (e_rv[v][p]) begin
          case (k)
            1: begin e_rd[v][p] = cmdm[v][dr]; e_tag[v][p] = "R1"; end
            3: begin e_rd[v][p] = msgm[v][dr][ix]; e_tag[v][p] = "R6"; end
            default: e_tag[v][p] = "R9";
          endcase
        end
      end
      for (int dd = 0; dd < 2; dd++) begin
        int unsigned clrm = 0;
        int wrp = -1;
        for (int p = 1; p >= 0; p--) begin
          lookup(v, ad[p], k, dr, ix);
          if (s[p] && w[p] && dr == dd) begin
            if (k == 1) wrp = p;
            if (k == 2) clrm |= wd[p] & 32'h1f;
          end
        end
        if (wrp >= 0) cmdm[v][dd] = wd[wrp] & 32'h1f;
        else          cmdm[v][dd] = cmdm[v][dd] & ~clrm;
        e_irq[v][dd] = (cmdm[v][dd] != 0);
      end
      for (int p = 1; p >= 0; p--) begin
        lookup(v, ad[p], k, dr, ix);
        if (s[p] && w[p] && k == 3) msgm[v][dr][ix] = wd[p];
      end
    end
  endtask

  task automatic chk(input string tag, input int unsigned act, input int unsigned exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all();
    chk(e_tag[0][0], a_hr, e_rd[0][0], "A host rdata");
    chk(e_tag[0][1], a_dr, e_rd[0][1], "A dsp rdata");
    chk(e_tag[1][0], b_hr, e_rd[1][0], "B host rdata");
    chk(e_tag[1][1], b_dr, e_rd[1][1], "B dsp rdata");
    chk("R8", a_hv, e_rv[0][0], "A host rvalid");
    chk("R8", a_dv, e_rv[0][1], "A dsp rvalid");
    chk("R8", b_hv, e_rv[1][0], "B host rvalid");
    chk("R8", b_dv, e_rv[1][1], "B dsp rvalid");
    chk("R2", a_irqd, e_irq[0][0], "A irq_dsp");
    chk("R2", a_irqh, e_irq[0][1], "A irq_host");
    chk("R2", b_irqd, e_irq[1][0], "B irq_dsp");
    chk("R2", b_irqh, e_irq[1][1], "B irq_host");
  endtask

  task automatic idle();
    h_sel = 0; h_we = 0; d_sel = 0; d_we = 0;
  endtask

  task automatic cyc();
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare_all();
    idle();
  endtask

  task automatic hw(input int a, input int unsigned v);
    h_sel = 1; h_we = 1; h_addr = 6'(a); h_wd = v;
  endtask
  task automatic dw(input int a, input int unsigned v);
    d_sel = 1; d_we = 1; d_addr = 6'(a); d_wd = v;
  endtask
  task automatic hr(input int a);
    h_sel = 1; h_we = 0; h_addr = 6'(a);
  endtask
  task automatic dr(input int a);
    d_sel = 1; d_we = 0; d_addr = 6'(a);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R8 watchdog: actual hang expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    for (int v = 0; v < 2; v++)
      for (int d = 0; d < 2; d++) begin
        cmdm[v][d] = 0; e_irq[v][d] = 0; e_rv[v][d] = 0; e_rd[v][d] = 0; e_tag[v][d] = "R8";
        for (int i = 0; i < 5; i++) msgm[v][d][i] = 0;
      end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    compare_all();  // reset state

    // R2: nonzero inbound command raises irq_dsp
    hw(0, 32'hffffffff); cyc();
    chk("R2", a_irqd, 1, "irq_dsp after doorbell");
    // R1: only five bits kept
    hr(0); cyc();
    chk("R1", a_hr, 32'h1f, "inbound cmd width");
    // R3: zero mask has no effect, ones clear
    dw(1, 0); cyc(); hr(0); cyc();
    chk("R3", a_hr, 32'h1f, "zero clear mask");
    dw(1, 3); cyc(); hr(0); cyc();
    chk("R3", a_hr, 32'h1c, "clear mask 3");
    // R4: plain write replaces content
    hw(0, 2); cyc(); hr(0); cyc();
    chk("R4", a_hr, 32'h2, "command replace");
    // R5: set and clear of the same bit in one cycle, set wins
    hw(0, 1); dw(1, 1); cyc(); hr(0); cyc();
    chk("R5", a_hr, 32'h1, "set beats clear");
    chk("R5", a_irqd, 1, "irq kept after collision");
    // R7: host wins a scratch collision
    hw(2, 32'haaaa); dw(2, 32'h5555); cyc(); dr(2); cyc();
    chk("R7", a_dr, 32'haaaa, "scratch collision");
    // R8: read returns pre-write value with one-cycle latency
    hw(2, 32'h1234); dr(2); cyc();
    chk("R8", a_dr, 32'haaaa, "read before write");
    chk("R8", a_dv, 1, "rvalid after read");
    cyc();
    chk("R8", a_dv, 0, "rvalid idle");
    // R6 / R10: outbound scratch word 4 at address 13, no interrupt effect
    dw(13, 32'hcafe); cyc(); hr(13); cyc();
    chk("R10", a_hr, 32'hcafe, "outbound scratch 4");
    chk("R6", a_irqh, 0, "scratch leaves irq_host low");
    // R2: outbound doorbell
    dw(7, 4); cyc();
    chk("R2", a_irqh, 1, "irq_host raised");
    hw(8, 4); cyc();
    chk("R2", a_irqh, 0, "irq_host cleared");
    // R9: unmapped and clear reads
    hw(20, 32'hffff); cyc(); hr(20); cyc();
    chk("R9", a_hr, 0, "unmapped read");
    hr(1); cyc();
    chk("R9", a_hr, 0, "clear register read");
    // R11: compact layout
    hw(1, 32'h1f); cyc();
    chk("R11", b_irqh, 1, "compact outbound cmd at 1");
    dw(3, 32'h1f); cyc();
    chk("R11", b_irqh, 0, "compact outbound clear at 3");
    hw(4, 32'h77); cyc(); hr(4); cyc();
    chk("R11", b_hr, 0, "compact has no scratch");

    // mixed random traffic, model compared every cycle
    for (int n = 0; n < 4000; n++) begin
      h_sel = ($urandom % 10) < 7; h_we = $urandom % 2;
      d_sel = ($urandom % 10) < 7; d_we = $urandom % 2;
      h_addr = ($urandom % 8 == 0) ? 6'($urandom % 64) : 6'($urandom % 15);
      d_addr = ($urandom % 8 == 0) ? 6'($urandom % 64) : 6'($urandom % 15);
      h_wd = ($urandom % 2) ? $urandom : $urandom % 32;
      d_wd = ($urandom % 2) ? $urandom : $urandom % 32;
      cyc();
    end

    done = 1;
    summary();
    $finish;
  end

endmodule